// File: doc/BRIEF.md
# Trigger Pattern Latch and Serializer

This block gathers the prompt hit flags of a set of anode-mode channels into one trigger pattern word. Each channel's sequencer reports a hit as a one-cycle pulse. The block keeps that hit as a sticky flag, but only when the channel is authorized. A lock strobe copies all flags into a shift register at once and clears them. Each shift step then moves the locked word out on a single serial line, lowest channel first.

The word is 27 positions long, or 18 positions in short mode, when the chip serves fewer cells. After the last bit of the word the line stays low. Hits that arrive after a lock go into the next word and leave the word already locked unchanged. The external trigger clock appears here as a shift-step strobe that is sampled on the block clock.

Top module: `trig_pattern_serializer`

## Requirements
- R1: After reset, serialOut is 0, no flag is pending, and the register is empty, so shift steps without a lock give 0.
- R2: A hitIn pulse on channel i while authMask[i] is 1 sets a flag that stays pending until the next lockStrobe, which places it at word position i.
- R3: A channel whose authMask bit is 0 contributes 0 to the locked word. This holds when it gets a hit while unauthorized, and when its authorization is removed before the lock.
- R4: lockStrobe copies all pending flags into the word in parallel. Hits that arrive after the lock, including hits during shifting, do not alter that word.
- R5: serialOut shows word position 0 right after the lock edge. Each clock with shiftStep high advances it by one position, and it holds its value while shiftStep is low.
- R6: After the last word position has been shifted, serialOut stays 0 for any further shift steps.
- R7: With shortMode=1, positions 18 to 26 are excluded (sent as 0), so exactly 18 steps empty the word. With shortMode=0 all 27 positions are sent.
- R8: A flag clears when a lock captures it. A hit that coincides with the lock strobe is not in the word being locked and stays pending for the next lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| shortMode | input | 1 | 1 selects the 18-position word, 0 selects the 27-position word |
| authMask | input | 27 | Per-channel authorization, 1 allows the channel to contribute |
| hitIn | input | 27 | Per-channel hit pulses from the channel sequencers |
| lockStrobe | input | 1 | Freezes the pending flags into the word and clears them |
| shiftStep | input | 1 | Advances the serial output by one position |
| serialOut | output | 1 | Serial trigger word, position 0 first |

## Verification
The bench locks and shifts several words: sparse alternating hits with every channel authorized, all channels hit under a partial authorization mask, and all channels hit in short mode. The first shows that bit order is kept. The second tells masking apart from flag capture, and the third shows that positions above 17 are truncated. Further runs inject hits in the middle of a shift and on the lock cycle itself, to show which word each hit lands in. One run holds the shift step low for several cycles, to show that the output holds its value rather than advancing.

// File: rtl/trig_pattern_pkg.sv
package trig_pattern_pkg;
  typedef struct packed {
    logic load;   // copy masked flags into the shift register
    logic shift;  // advance shift register by one position
    logic clear;  // clear captured flags
  } trigStrobes_t;
endpackage

// File: rtl/trig_pattern_ctrl.sv
module trig_pattern_ctrl
  import trig_pattern_pkg::*;
#(
  parameter int NUM_CH   = 27,
  parameter int SHORT_CH = 18,
  localparam int CW      = $clog2(NUM_CH + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         shortMode,
  input  logic         lockStrobe,
  input  logic         shiftStep,
  output trigStrobes_t strobes,
  output logic [CW-1:0] bitsLeft
);
  localparam logic [CW-1:0] LONG_LEN  = CW'(NUM_CH);
  localparam logic [CW-1:0] SHORT_LEN = CW'(SHORT_CH);

  logic [CW-1:0] leftQ;
  logic          haveBits;

  assign haveBits = (leftQ != '0);

  always_comb begin
    strobes.load  = lockStrobe;
    strobes.clear = lockStrobe;
    strobes.shift = shiftStep && !lockStrobe && haveBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftQ <= '0;
    end else if (strobes.load) begin
      leftQ <= shortMode ? SHORT_LEN : LONG_LEN;
    end else if (strobes.shift) begin
      leftQ <= leftQ - 1'b1;
    end
  end

  assign bitsLeft = leftQ;
endmodule

// File: rtl/trig_pattern_datapath.sv
module trig_pattern_datapath
  import trig_pattern_pkg::*;
#(
  parameter int NUM_CH   = 27,
  parameter int SHORT_CH = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shortMode,
  input  logic [NUM_CH-1:0] authMask,
  input  logic [NUM_CH-1:0] hitIn,
  input  trigStrobes_t      strobes,
  output logic [NUM_CH-1:0] flagState,
  output logic [NUM_CH-1:0] shiftState,
  output logic              serialOut
);
  logic [NUM_CH-1:0] flagQ;
  logic [NUM_CH-1:0] shiftQ;
  logic [NUM_CH-1:0] keepMask;
  logic [NUM_CH-1:0] capture;

  // Position filter: in short mode the upper positions never load.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_keep
    if (i < SHORT_CH) begin : g_low
      assign keepMask[i] = 1'b1;
    end else begin : g_high
      assign keepMask[i] = !shortMode;
    end
  end

  assign capture = flagQ & authMask & keepMask;

  // Per-channel sticky hit flags; a new hit wins over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
    end else begin
      flagQ <= (flagQ & ~{NUM_CH{strobes.clear}}) | (hitIn & authMask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (strobes.load) begin
      shiftQ <= capture;
    end else if (strobes.shift) begin
      shiftQ <= {1'b0, shiftQ[NUM_CH-1:1]};
    end
  end

  assign flagState  = flagQ;
  assign shiftState = shiftQ;
  assign serialOut  = shiftQ[0];
endmodule

// File: rtl/trig_pattern_serializer.sv
module trig_pattern_serializer
  import trig_pattern_pkg::*;
#(
  parameter int NUM_CH   = 27,
  parameter int SHORT_CH = 18,
  localparam int CW      = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shortMode,
  input  logic [NUM_CH-1:0] authMask,
  input  logic [NUM_CH-1:0] hitIn,
  input  logic              lockStrobe,
  input  logic              shiftStep,
  output logic              serialOut
);
  trigStrobes_t      strobes;
  logic [CW-1:0]     bitsLeft;
  logic [NUM_CH-1:0] flagState;
  logic [NUM_CH-1:0] shiftState;

  trig_pattern_ctrl #(.NUM_CH(NUM_CH), .SHORT_CH(SHORT_CH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .shortMode  (shortMode),
    .lockStrobe (lockStrobe),
    .shiftStep  (shiftStep),
    .strobes    (strobes),
    .bitsLeft   (bitsLeft)
  );

  trig_pattern_datapath #(.NUM_CH(NUM_CH), .SHORT_CH(SHORT_CH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .shortMode  (shortMode),
    .authMask   (authMask),
    .hitIn      (hitIn),
    .strobes    (strobes),
    .flagState  (flagState),
    .shiftState (shiftState),
    .serialOut  (serialOut)
  );
endmodule

// File: rtl/trig_pattern_chk.sv
module trig_pattern_chk #(
  parameter int NUM_CH   = 27,
  parameter int SHORT_CH = 18,
  localparam int CW      = $clog2(NUM_CH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              shortMode,
  input logic [NUM_CH-1:0] authMask,
  input logic [NUM_CH-1:0] hitIn,
  input logic              lockStrobe,
  input logic              shiftStep,
  input logic              serialOut,
  input logic [CW-1:0]     bitsLeft,
  input logic [NUM_CH-1:0] flagState,
  input logic [NUM_CH-1:0] shiftState
);
  // R1: the first cycle out of reset shows an empty line
  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rstN) |-> (serialOut == 1'b0 && shiftState == '0));

  // R3: no flag rises without an authorized hit
  a_r3_no_unauth_flag: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagState & ~$past(flagState) & ~$past(hitIn & authMask)) == '0));

  // R5: without a step or a lock the output holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftStep && !lockStrobe) |=> $stable(serialOut));

  // R6: once the control counts the word empty, the line is low
  a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    (bitsLeft == '0 && !lockStrobe) |=> (serialOut == 1'b0));

  // R7: short mode never loads the excluded positions
  a_r7_short_trunc: assert property (@(posedge clk) disable iff (!rstN)
    (lockStrobe && shortMode) |=> (shiftState[NUM_CH-1:SHORT_CH] == '0));

  // R8: after a lock only same-cycle authorized hits remain pending
  a_r8_clear_on_lock: assert property (@(posedge clk) disable iff (!rstN)
    lockStrobe |=> ((flagState & ~$past(hitIn & authMask)) == '0));
endmodule

bind trig_pattern_serializer trig_pattern_chk #(.NUM_CH(NUM_CH), .SHORT_CH(SHORT_CH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .shortMode  (shortMode),
  .authMask   (authMask),
  .hitIn      (hitIn),
  .lockStrobe (lockStrobe),
  .shiftStep  (shiftStep),
  .serialOut  (serialOut),
  .bitsLeft   (bitsLeft),
  .flagState  (flagState),
  .shiftState (shiftState)
);

// File: tb/sim_trig_pattern_serializer.sv
`timescale 1ns/1ps
module sim_trig_pattern_serializer;
  localparam int NCH = 27;
  localparam int NSH = 18;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           shortMode = 1'b0;
  logic [NCH-1:0] authMask = '0;
  logic [NCH-1:0] hitIn = '0;
  logic           lockStrobe = 1'b0;
  logic           shiftStep = 1'b0;
  logic           serialOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic sampleReq = 1'b0;

  typedef struct { logic val; string tag; } expItem_t;
  expItem_t expQ[$];
  logic [NCH-1:0] pend = '0;

  always #5 clk = ~clk;

  trig_pattern_serializer u0 (
    .clk(clk), .rstN(rstN), .shortMode(shortMode), .authMask(authMask),
    .hitIn(hitIn), .lockStrobe(lockStrobe), .shiftStep(shiftStep),
    .serialOut(serialOut)
  );

  // Monitor: pops one expected bit per requested sample, away from the edge.
  always @(negedge clk) begin
    if (sampleReq) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual=%0b expected=none", serialOut);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (serialOut !== it.val) begin
          errors++;
          $display("FAIL %s: serialOut actual=%0b expected=%0b", it.tag, serialOut, it.val);
        end
      end
    end
  end

  function automatic logic [NCH-1:0] keepBits(input logic sm);
    logic [NCH-1:0] k;
    for (int i = 0; i < NCH; i++) k[i] = (i < NSH) || !sm;
    return k;
  endfunction

  task automatic pulseHits(input logic [NCH-1:0] h);
    @(posedge clk); #2;
    hitIn = h;
    pend |= h & authMask;
    @(posedge clk); #2;
    hitIn = '0;
  endtask

  // Lock, optionally hold, then step; hits can be injected on the lock cycle and mid-shift.
  task automatic lockShift(input logic [NCH-1:0] hitAtLock, input int holdCyc,
                           input int nStep, input logic [NCH-1:0] hitMid, input string tag);
    logic [NCH-1:0] word;
    int len;
    len = shortMode ? NSH : NCH;
    @(posedge clk); #2;
    lockStrobe = 1'b1;
    hitIn = hitAtLock;
    word = pend & authMask & keepBits(shortMode);
    pend = hitAtLock & authMask;
    @(posedge clk); #2;
    lockStrobe = 1'b0;
    hitIn = '0;
    for (int h = 0; h < holdCyc; h++) begin
      expQ.push_back('{word[0], "R5"});
      sampleReq = 1'b1;
      @(posedge clk); #2;
    end
    for (int k = 0; k < nStep; k++) begin
      if (k < len) expQ.push_back('{word[k], tag});
      else         expQ.push_back('{1'b0, shortMode ? "R7" : "R6"});
      sampleReq = 1'b1;
      shiftStep = 1'b1;
      if (k == 3) begin
        hitIn = hitMid;
        pend |= hitMid & authMask;
      end
      @(posedge clk); #2;
      hitIn = '0;
    end
    shiftStep = 1'b0;
    sampleReq = 1'b0;
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rstN = 1'b1;
    // R1: reset state, then steps with nothing locked stay 0
    @(negedge clk);
    checks++;
    if (serialOut !== 1'b0) begin
      errors++;
      $display("FAIL R1: serialOut actual=%0b expected=0", serialOut);
    end
    @(posedge clk); #2;
    for (int k = 0; k < 4; k++) begin
      expQ.push_back('{1'b0, "R1"});
      sampleReq = 1'b1;
      shiftStep = 1'b1;
      @(posedge clk); #2;
    end
    shiftStep = 1'b0;
    sampleReq = 1'b0;

    // R2/R4/R6: sparse pattern, all authorized, hits mid-shift go to next word
    authMask = '1;
    pulseHits(27'h2A5_5A5A);
    lockShift('0, 0, NCH + 3, 27'h000_00F0, "R2");
    // R4: the mid-shift hits appear only in the following word
    lockShift('0, 0, NCH + 1, '0, "R4");

    // R3: partial authorization with every channel hit
    authMask = 27'h123_4567;
    pulseHits('1);
    lockShift('0, 0, NCH + 1, '0, "R3");
    // R3: authorization removed after the hit, before the lock
    authMask = '1;
    pulseHits(27'h000_0FFF);
    authMask = 27'h7FF_F0F0;
    lockShift('0, 0, NCH, '0, "R3");
    authMask = '1;

    // R5: hold without steps, then shift
    pulseHits(27'h000_0001);
    lockShift('0, 3, 4, '0, "R5");

    // R7: short mode, all hit
    shortMode = 1'b1;
    pulseHits('1);
    lockShift('0, 0, NCH + 2, '0, "R7");
    shortMode = 1'b0;

    // R8: hit on the lock cycle is kept for the next lock
    pulseHits(27'h000_0003);
    lockShift(27'h400_0100, 0, NCH, '0, "R8");
    lockShift('0, 0, NCH, '0, "R8");
    // R8: flags cleared by capture leave an empty next word
    lockShift('0, 0, 5, '0, "R8");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule